// File: doc/BRIEF.md
# In-Place Memory Add-Constant Engine

This block is a bus-mastering accelerator that adds one signed 32-bit constant to every word of a region in external memory, in place. A control block supplies a base byte address, a signed word count and the addend on plain input ports, then pulses `start`. The engine fetches the region in read bursts into a small local word buffer, adding the constant as each beat arrives. It then writes the buffer back to the same addresses in a write burst. After the last write response it pulses `done`.

The memory side is a reduced AXI4 master with five channels: read address, read data, write address, write data and write response. Every channel uses valid/ready. A beat moves only in a cycle where both valid and ready are high. The engine holds each valid, and the payload beside it, unchanged until the matching ready is seen. The subordinate may withhold `m_arready`, `m_rvalid`, `m_awready`, `m_wready` and `m_bvalid` for any number of cycles without loss. The engine keeps `m_rready` and `m_bready` high for as long as it is waiting on those channels. Response codes, address translation and error recovery are not handled.

Top module: `mem_add_engine`

## Requirements
- R1: When the engine finishes, each word i (0 <= i < length) of the region holds its former value plus the addend, wrapped modulo 2^32. Words outside the region are unchanged.
- R2: Word i is read from and written back to byte address base + 4*i. The two low bits of the base are treated as zero.
- R3: No burst carries more than BUF_WORDS (default 50) beats. A region longer than that is split into chunks, and each chunk is read completely before its write address is issued.
- R4: No read or write burst crosses a 4096-byte address boundary. A chunk that would cross one is shortened so that it ends at the boundary.
- R5: A start with a length of zero or below makes `done` pulse on the next cycle. No address is issued on either channel and memory is left untouched.
- R6: `done` is a single-cycle pulse. For a non-empty region it rises only after the write response of the final burst has been accepted, with no write data or response left outstanding.
- R7: A start pulse while `busy` is high is ignored. The run already in progress finishes with its original base, length and addend.
- R8: Every burst is INCR type (`arburst`/`awburst` = 2'b01) with a 4-byte beat size (`arsize`/`awsize` = 3'd2), len = beats - 1, all byte strobes set (4'hF), and `m_wlast` high on the final write beat only.
- R9: Once `m_arvalid`, `m_awvalid` or `m_wvalid` is raised, it stays high with its address, length, data and last flag unchanged until the matching ready is seen.
- R10: Out of reset, `busy`, `done`, `m_arvalid`, `m_awvalid` and `m_wvalid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| base_addr | input | 32 | Byte address of word 0 |
| length | input | 32 | Signed word count |
| addend | input | 32 | Signed constant added to each word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| m_araddr | output | 32 | Read burst start address |
| m_arlen | output | 8 | Read beats minus one |
| m_arsize | output | 3 | Read beat size code (2 = 4 bytes) |
| m_arburst | output | 2 | Read burst type (INCR) |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | 32 | Write burst start address |
| m_awlen | output | 8 | Write beats minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type (INCR) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data beat |
| m_wstrb | output | 4 | Write byte strobes |
| m_wlast | output | 1 | Final write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The hardest situation to reach is a chunk that is cut short by a 4 KB boundary while it is also capped by the buffer size. A short burst must be followed by a full one, with the address arithmetic carried across the boundary, and all of this under random stalls on every channel. Directed runs place the base a few words below a boundary with lengths well above the buffer size. Random runs then draw bases and lengths across the whole model memory, and the bench counts the expected bursts with its own split rule. A second start in the middle of a run, with different parameters, shows through the final memory contents whether it was wrongly taken.

// File: rtl/mem_add_pkg.sv
package mem_add_pkg;
  localparam int unsigned PAGE_BYTES = 4096;
  localparam int unsigned WORD_BYTES = 4;
  typedef enum logic [2:0] {
    ST_IDLE, ST_AR, ST_R, ST_AW, ST_W, ST_B
  } eng_state_e;
endpackage

// File: rtl/mae_burst_plan.sv
module mae_burst_plan #(
  parameter int unsigned BUF_WORDS  = 50,
  parameter int unsigned PAGE_BYTES = 4096,
  localparam int unsigned PG_W  = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W = $clog2(BUF_WORDS + 1)
) (
  input  logic [PG_W-1:0]  page_off,
  input  logic [31:0]      words_left,
  output logic [CNT_W-1:0] burst_words
);
  logic [31:0] room;
  logic [31:0] n;

  always_comb begin
    room = (32'(PAGE_BYTES) - 32'(page_off)) >> 2;
    n = words_left;
    if (n > 32'(BUF_WORDS)) n = 32'(BUF_WORDS);
    if (n > room) n = room;
    burst_words = CNT_W'(n);
  end
endmodule

// File: rtl/mae_word_buf.sv
module mae_word_buf #(
  parameter int unsigned DEPTH  = 50,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_data;
  end

  assign rd_data = slots[rd_idx];

  // R3
  buf_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> 32'(wr_idx) < DEPTH);
endmodule

// File: rtl/mem_add_engine.sv
module mem_add_engine #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BUF_WORDS = 50,
  localparam int unsigned DATA_W = 32,
  localparam int unsigned CNT_W  = $clog2(BUF_WORDS + 1),
  localparam int unsigned IDX_W  = $clog2(BUF_WORDS),
  localparam int unsigned PG_W   = $clog2(mem_add_pkg::PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [31:0]       length,
  input  logic [DATA_W-1:0] addend,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [3:0]        m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic              m_bvalid,
  output logic              m_bready
);
  import mem_add_pkg::*;

  eng_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [31:0]       left;
  logic [DATA_W-1:0] add_q;
  logic [CNT_W-1:0]  beats;
  logic [IDX_W-1:0]  idx;
  logic              done_q;
  logic [CNT_W-1:0]  plan_n;
  logic              last_beat;
  logic [DATA_W-1:0] buf_out;

  mae_burst_plan #(.BUF_WORDS(BUF_WORDS), .PAGE_BYTES(PAGE_BYTES)) u_plan (
    .page_off   (cur_addr[PG_W-1:0]),
    .words_left (left),
    .burst_words(plan_n)
  );

  mae_word_buf #(.DEPTH(BUF_WORDS), .DATA_W(DATA_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (state == ST_R && m_rvalid),
    .wr_idx (idx),
    .wr_data(m_rdata + add_q),
    .rd_idx (idx),
    .rd_data(buf_out)
  );

  assign last_beat = (32'(idx) == 32'(beats) - 32'd1);

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign m_araddr  = cur_addr;
  assign m_arlen   = 8'(plan_n) - 8'd1;
  assign m_arsize  = 3'd2;
  assign m_arburst = 2'b01;
  assign m_arvalid = (state == ST_AR);
  assign m_rready  = (state == ST_R);
  assign m_awaddr  = cur_addr;
  assign m_awlen   = 8'(beats) - 8'd1;
  assign m_awsize  = 3'd2;
  assign m_awburst = 2'b01;
  assign m_awvalid = (state == ST_AW);
  assign m_wdata   = buf_out;
  assign m_wstrb   = 4'hF;
  assign m_wlast   = (state == ST_W) && last_beat;
  assign m_wvalid  = (state == ST_W);
  assign m_bready  = (state == ST_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      left     <= '0;
      add_q    <= '0;
      beats    <= '0;
      idx      <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          if ($signed(length) <= 0) begin
            done_q <= 1'b1;
          end else begin
            cur_addr <= {base_addr[ADDR_W-1:2], 2'b00};
            left     <= length;
            add_q    <= addend;
            state    <= ST_AR;
          end
        end
        ST_AR: if (m_arready) begin
          beats <= plan_n;
          idx   <= '0;
          state <= ST_R;
        end
        ST_R: if (m_rvalid) begin
          if (last_beat) begin
            idx   <= '0;
            state <= ST_AW;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_AW: if (m_awready) state <= ST_W;
        ST_W: if (m_wready) begin
          if (last_beat) state <= ST_B;
          else idx <= idx + 1'b1;
        end
        ST_B: if (m_bvalid) begin
          cur_addr <= cur_addr + (ADDR_W'(beats) << 2);
          left     <= left - 32'(beats);
          if (left == 32'(beats)) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state <= ST_AR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));
  // R9
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));
  // R3
  ar_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> 32'(m_arlen) < BUF_WORDS);
  // R4
  ar_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> 32'(m_araddr[PG_W-1:0]) + ((32'(m_arlen) + 32'd1) << 2) <= PAGE_BYTES);
  // R6
  done_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(m_bvalid && m_bready) || $past(start && !busy));
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(add_q));
  // R3
  no_read_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |=> !m_arvalid);
endmodule

// File: tb/mem_add_engine_bench.sv
`timescale 1ns/1ps
module mem_add_engine_bench;
  localparam int MW = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] base_addr = '0, length = '0, addend = '0;
  logic        busy, done;
  logic [31:0] m_araddr, m_awaddr, m_rdata, m_wdata;
  logic [7:0]  m_arlen, m_awlen;
  logic [2:0]  m_arsize, m_awsize;
  logic [1:0]  m_arburst, m_awburst;
  logic [3:0]  m_wstrb;
  logic        m_arvalid, m_rready, m_awvalid, m_wlast, m_wvalid, m_bready;
  logic        m_arready = 1'b0, m_rvalid = 1'b0, m_awready = 1'b0;
  logic        m_wready = 1'b0, m_bvalid = 1'b0;

  mem_add_engine u_mem_add_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .length(length), .addend(addend), .busy(busy), .done(done),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
    .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_bvalid(m_bvalid),
    .m_bready(m_bready));

  logic [31:0] mem [MW];
  logic [31:0] shadow [MW];
  int total = 0, bad = 0;
  int ar_cnt, aw_cnt, cap_bad, page_bad, fmt_bad, order_bad, done_bad, done_cnt;
  int rd_left = 0, wr_left = 0;
  logic [31:0] rd_addr = '0, wr_addr = '0;
  bit b_pend = 0;

  function automatic int widx(logic [31:0] a);
    return int'((a >> 2) & 32'(MW - 1));
  endfunction

  function automatic bit crosses(logic [31:0] a, logic [7:0] l);
    return (int'(a & 32'hFFF) + (int'(l) + 1) * 4) > 4096;
  endfunction

  // memory subordinate model with random stalls
  always @(posedge clk) begin
    if (!rst_n) begin
      m_arready <= 0; m_rvalid <= 0; m_awready <= 0; m_wready <= 0; m_bvalid <= 0;
    end else begin
      if (m_arvalid && m_arready) begin
        ar_cnt++;
        if (int'(m_arlen) >= 50) cap_bad++;
        if (crosses(m_araddr, m_arlen)) page_bad++;
        if (m_arsize != 3'd2 || m_arburst != 2'b01) fmt_bad++;
        rd_addr = m_araddr; rd_left = int'(m_arlen) + 1;
      end
      if (m_rvalid && m_rready) begin
        rd_addr = rd_addr + 4; rd_left--;
      end
      if (!(m_rvalid && !m_rready)) begin
        m_rvalid <= (rd_left > 0) && ($urandom % 4 != 0);
        m_rdata  <= mem[widx(rd_addr)];
      end
      if (m_awvalid && m_awready) begin
        aw_cnt++;
        if (int'(m_awlen) >= 50) cap_bad++;
        if (crosses(m_awaddr, m_awlen)) page_bad++;
        if (m_awsize != 3'd2 || m_awburst != 2'b01) fmt_bad++;
        if (rd_left != 0 || m_rvalid) order_bad++;
        wr_addr = m_awaddr; wr_left = int'(m_awlen) + 1;
      end
      if (m_wvalid && m_wready) begin
        if (wr_left == 0 || m_wstrb != 4'hF || m_wlast != (wr_left == 1)) fmt_bad++;
        mem[widx(wr_addr)] = m_wdata;
        wr_addr = wr_addr + 4; wr_left--;
        if (wr_left == 0) b_pend = 1;
      end
      if (m_bvalid && m_bready) begin
        m_bvalid <= 0; b_pend = 0;
      end else if (b_pend && !m_bvalid && ($urandom % 3 == 0)) begin
        m_bvalid <= 1;
      end
      if (done) begin
        done_cnt++;
        if (wr_left != 0 || b_pend || m_bvalid) done_bad++;
      end
      m_arready <= ($urandom % 3 != 0);
      m_awready <= ($urandom % 3 != 0);
      m_wready  <= ($urandom % 4 != 0);
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_bursts(logic [31:0] b, int len);
    int cnt = 0;
    int a = int'(b & 32'hFFFF_FFFC);
    int l = len;
    while (l > 0) begin
      int room = (4096 - (a % 4096)) / 4;
      int n = l;
      if (n > 50) n = 50;
      if (n > room) n = room;
      a += 4 * n; l -= n; cnt++;
    end
    return cnt;
  endfunction

  task automatic prep();
    for (int i = 0; i < MW; i++) shadow[i] = mem[i];
    ar_cnt = 0; aw_cnt = 0; cap_bad = 0; page_bad = 0; fmt_bad = 0;
    order_bad = 0; done_bad = 0; done_cnt = 0;
  endtask

  task automatic cmp_mem(logic [31:0] b, int len, logic [31:0] add, string tag);
    int first = (len > 0) ? widx(b) : -1;
    int miss = 0, mi = 0;
    logic [31:0] ma = '0, me = '0;
    for (int i = 0; i < MW; i++) begin
      logic [31:0] e = shadow[i];
      if (len > 0 && i >= first && i < first + len) e = shadow[i] + add;
      if (mem[i] !== e) begin
        if (miss == 0) begin mi = i; ma = mem[i]; me = e; end
        miss++;
      end
    end
    chk(miss == 0, tag, $sformatf("memory word %0d", mi), longint'(ma), longint'(me));
  endtask

  task automatic run(logic [31:0] b, int len, logic [31:0] add, bit restart);
    int cyc = 0;
    prep();
    @(negedge clk);
    base_addr = b; length = 32'(len); addend = add; start = 1;
    @(negedge clk);
    start = 0;
    if (restart) begin
      repeat (6) @(negedge clk);
      // R7: second start while busy, different parameters
      chk(busy == 1, "R7", "busy before second start", busy, 1);
      base_addr = 32'h40; length = 3; addend = 32'd99; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
    chk(done == 1, "R6", "done seen", done, 1);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R6", "done single pulse", done, 0);
    cmp_mem(b, len, add, restart ? "R7" : "R1");
    chk(ar_cnt == exp_bursts(b, len) && aw_cnt == ar_cnt, "R4",
        "burst count", ar_cnt, exp_bursts(b, len));
    chk(cap_bad == 0, "R3", "burst over buffer size", cap_bad, 0);
    chk(page_bad == 0, "R4", "4KB crossing", page_bad, 0);
    chk(order_bad == 0, "R3", "write before read complete", order_bad, 0);
    chk(fmt_bad == 0, "R8", "burst format", fmt_bad, 0);
    chk(done_bad == 0 && done_cnt == 1, "R6", "done timing", done_cnt, 1);
  endtask

  task automatic run_empty(int len);
    prep();
    @(negedge clk);
    base_addr = 32'h100; length = 32'(len); addend = 32'd5; start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1, "R5", "done next cycle", done, 1);
    repeat (10) @(negedge clk);
    chk(ar_cnt == 0 && aw_cnt == 0, "R5", "no bus traffic", ar_cnt + aw_cnt, 0);
    chk(busy == 0 && done_cnt == 1, "R5", "single done, idle", done_cnt, 1);
    cmp_mem(32'h100, 0, 0, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MW; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    // R10
    chk(!busy && !done && !m_arvalid && !m_awvalid && !m_wvalid, "R10",
        "reset outputs", {busy, done, m_arvalid, m_awvalid, m_wvalid}, 0);
    rst_n = 1;
    @(negedge clk);
    run(32'h0, 1, 32'd7, 0);                  // R1 single word
    run(32'h100, 50, 32'hFFFF_FFFD, 0);       // R3 exactly one full burst
    run(32'h400, 51, 32'd3, 0);               // R3 one word over
    mem[widx(32'h2000)] = 32'h7FFF_FFF0;
    run(32'h2000, 4, 32'h0000_0020, 0);       // R1 wraparound
    run(32'hFF8, 10, 32'd1, 0);               // R4 split at boundary
    run(32'h1F00, 200, 32'h8000_0000, 0);     // R4 long, boundary and cap
    run(32'h3003, 5, 32'd11, 0);              // R2 unaligned base
    run(32'h800, 120, 32'd42, 1);             // R7 start while busy
    run_empty(0);                             // R5
    run_empty(-5);                            // R5
    for (int k = 0; k < 8; k++) begin
      int len = 1 + int'($urandom % 180);
      logic [31:0] b = 32'(($urandom % (MW - len - 2)) * 4);
      run(b, len, $urandom, 0);               // R1 R2 random
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule